// File: doc/BRIEF.md
# Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic and logic unit of parameterised width, 32 bits by default. Two operands and a 3-bit operation code go in. The unit returns a result word and three flags: zero, signed overflow and carry-out. Five operations are supported: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Subtraction has no adder of its own. It reuses the single adder by complementing the second operand and forcing the incoming carry to one.

The set-on-less-than result is taken from the sign of that shared subtraction. It is corrected with the overflow flag and steered into bit 0 of the result. The overflow flag is an indication only. A surrounding pipeline may trap on it or ignore it.

The block has no storage and no handshake. Its outputs follow its inputs within the same cycle, so it can sit directly in an execute stage between operand and result registers. Because nothing is held or queued inside the block, no valid/ready flow or back-pressure applies.

Top module: `int_alu`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of the two operands.
- R2: Code 3'b001 returns the bitwise OR of the two operands.
- R3: Code 3'b010 returns the sum of the operands modulo 2^WIDTH.
- R4: Code 3'b110 returns operand a minus operand b modulo 2^WIDTH.
- R5: Code 3'b111 returns 1 in bit 0 when a is less than b as signed two's-complement values, and 0 otherwise. All higher result bits are 0. The comparison stays correct when the internal subtraction overflows.
- R6: For codes 3'b010, 3'b110 and 3'b111, the overflow flag is set exactly when the signed sum or difference does not fit in WIDTH bits. Adding values of opposite sign, or subtracting values of equal sign, never sets it.
- R7: For codes 3'b000, 3'b001 and for the unused codes, the overflow flag is 0.
- R8: For every code, the carry-out is bit WIDTH of a + (op[2] ? ~b : b) + op[2], taken as an unsigned sum. Bit 2 of the code is the operand-invert control.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 return an all-zero result.
- R10: The zero flag is 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand; it is complemented when op_i[2] is set |
| op_i | input | 3 | Operation code |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when res_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add, subtract or compare |
| cout_o | output | 1 | Raw carry out of the most significant adder position |

## Verification
The bench builds the unit with WIDTH set to 4. At that width, every pairing of the two operands can be crossed with all eight operation codes in a little over two thousand vectors. The sweep therefore covers every overflowing add and subtract, every compare of the most negative value against a positive value, and every unused code. Each expected value is worked out with plain signed and unsigned integer arithmetic.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Slice output selector, taken from the low two bits of the code.
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;

  function automatic logic op_is_legal(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT);
  endfunction

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
  endfunction

endpackage

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_in_o,
  output logic             c_msb_out_o
);
  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0] full;

  always_comb begin
    full        = {1'b0, x_i} + {1'b0, y_i} + {{(EXT-1){1'b0}}, cin_i};
    sum_o       = full[WIDTH-1:0];
    c_msb_out_o = full[WIDTH];
    // The carry entering the top position is recovered from its sum bit.
    c_msb_in_o  = x_i[WIDTH-1] ^ y_i[WIDTH-1] ^ full[WIDTH-1];
  end
endmodule

// File: rtl/int_alu_slice.sv
module int_alu_slice
  import int_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       sum_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o
);
  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_i;
      SEL_OR:   res_o = a_i | b_i;
      SEL_SUM:  res_o = sum_i;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic             binv;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             c_in_top;
  logic             c_out_top;
  logic             raw_ovf;
  logic             less_bit;
  logic [WIDTH-1:0] slice_res;
  logic             legal;

  assign binv  = op_i[2];
  assign b_eff = opb_i ^ {WIDTH{binv}};

  int_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i        (opa_i),
    .y_i        (b_eff),
    .cin_i      (binv),
    .sum_o      (sum),
    .c_msb_in_o (c_in_top),
    .c_msb_out_o(c_out_top)
  );

  assign raw_ovf  = c_in_top ^ c_out_top;
  assign less_bit = sum[MSB] ^ raw_ovf;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      int_alu_slice u_slice (
        .a_i   (opa_i[i]),
        .b_i   (opb_i[i]),
        .sum_i (sum[i]),
        .less_i(less_bit),
        .sel_i (op_i[1:0]),
        .res_o (slice_res[i])
      );
    end else begin : g_upper
      int_alu_slice u_slice (
        .a_i   (opa_i[i]),
        .b_i   (opb_i[i]),
        .sum_i (sum[i]),
        .less_i(1'b0),
        .sel_i (op_i[1:0]),
        .res_o (slice_res[i])
      );
    end
  end

  assign legal  = op_is_legal(op_i);
  assign res_o  = legal ? slice_res : '0;
  assign zero_o = ~|res_o;
  assign ovf_o  = op_is_arith(op_i) & raw_ovf;
  assign cout_o = c_out_top;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             cout_o
);
  always_comb begin
    if (!$isunknown(op_i) && !$isunknown(opa_i) && !$isunknown(opb_i)) begin
      // R9
      unused_zero_chk: assert (!(op_i inside {3'b011, 3'b100, 3'b101}) || res_o == '0);
      // R7
      no_overflow_chk: assert (op_i[1] || !ovf_o);
      // R6
      mixed_sign_add_chk: assert (!(op_i == 3'b010 && opa_i[WIDTH-1] != opb_i[WIDTH-1]) || !ovf_o);
      // R5
      slt_upper_clear_chk: assert (op_i != 3'b111 || res_o[WIDTH-1:1] == '0);
      // R4
      sub_self_zero_chk: assert (!(op_i == 3'b110 && opa_i == opb_i) || (zero_o && !ovf_o));
      // R3
      add_identity_chk: assert (!(op_i == 3'b010 && opb_i == '0) || (res_o == opa_i && !cout_o));
    end
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i (opa_i),
  .opb_i (opb_i),
  .op_i  (op_i),
  .res_o (res_o),
  .zero_o(zero_o),
  .ovf_o (ovf_o),
  .cout_o(cout_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] res;
  logic         zero, ovf, cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  int_alu #(.WIDTH(W)) uut (
    .opa_i (a), .opb_i(b), .op_i(op),
    .res_o (res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  function automatic int sx(input int v);
    return (v >= HALF) ? v - (1 << W) : v;
  endfunction

  task automatic one(input int op_v, input int av, input int bv);
    int sa, sb, beff, full, e_res, e_cout, e_ovf, e_zero, s;
    string tag;
    sa = sx(av); sb = sx(bv);
    beff = op_v[2] ? (~bv) & MASK : bv;
    full = av + beff + op_v[2];
    e_cout = (full >> W) & 1;
    e_ovf = 0;
    case (op_v)
      0: begin e_res = av & bv; tag = "R1"; end
      1: begin e_res = av | bv; tag = "R2"; end
      2: begin e_res = (av + bv) & MASK; tag = "R3"; s = sa + sb;
               e_ovf = (s >= HALF || s < -HALF) ? 1 : 0; end
      6: begin e_res = (av - bv) & MASK; tag = "R4"; s = sa - sb;
               e_ovf = (s >= HALF || s < -HALF) ? 1 : 0; end
      7: begin e_res = (sa < sb) ? 1 : 0; tag = "R5"; s = sa - sb;
               e_ovf = (s >= HALF || s < -HALF) ? 1 : 0; end
      default: begin e_res = 0; tag = "R9"; end
    endcase
    e_zero = (e_res == 0) ? 1 : 0;
    @(posedge clk);
    op <= 3'(op_v); a <= W'(av); b <= W'(bv);
    @(negedge clk);
    checks++;
    if (int'(res) != e_res) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d result got %0d exp %0d", tag, op_v, av, bv, res, e_res);
    end
    if (int'(zero) != e_zero) begin
      errors++;
      $display("FAIL R10 op=%0d a=%0d b=%0d zero got %0d exp %0d", op_v, av, bv, zero, e_zero);
    end
    if (int'(ovf) != e_ovf) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d overflow got %0d exp %0d",
               (op_v == 2 || op_v >= 6) ? "R6" : "R7", op_v, av, bv, ovf, e_ovf);
    end
    if (int'(cout) != e_cout) begin
      errors++;
      $display("FAIL R8 op=%0d a=%0d b=%0d carry got %0d exp %0d", op_v, av, bv, cout, e_cout);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state: zero operands, AND code -> zero result, zero flag set (R10).
    checks++;
    if (res !== '0 || zero !== 1'b1 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset result got %0d/%0d exp 0/1", res, zero);
    end
    rst = 1'b0;
    // Sweep covers R1 R2 R3 R4 R5 R6 R7 R8 R9 R10.
    for (int o = 0; o < 8; o++)
      for (int x = 0; x <= MASK; x++)
        for (int y = 0; y <= MASK; y++)
          one(o, x, y);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule